// File: doc/BRIEF.md
# DMA Command-Completion Event Counter

This block keeps the per-channel completion accounting for a DMA channel. A sequencer outside the block sends a one-cycle pulse when it loads a command list and another each time a command finishes. The block counts these pulses in a wrapping hardware count. Software keeps a second wrapping count of the events it has already handled. An interrupt-active flag is set by every event, and a level interrupt is driven from that flag, gated by an enable bit.

Software reads both counts and the flag from one packed register. It acknowledges events by writing back the count it has handled, with the flag bit at zero. If a new event arrives while that write is taking place, the event is still counted. The flag also stays set, so the late event cannot be lost. The number of events still to handle is the hardware count minus the handled count, modulo 64.

A second counter reports the bytes remaining in the active command, for residue reporting. It loads the command's size field when the command starts and counts down by the beat width on each accepted beat. The register port is a plain single-cycle read/write port with a word index. Word 0 holds the configuration, word 1 the counters and word 2 the remaining bytes.

Top module: `dma_evt_acct`

## Requirements
- R1: After a synchronous reset, words 0, 1 and 2 read zero and `irq` is low.
- R2: Word 1 reads the hardware done count in bits 5:0, the interrupt-active flag in bit 8 and the handled count in bits 21:16. All other bits read zero. Word 3 reads zero.
- R3: Each cycle with `evt_pulse` high raises the done count by exactly one, modulo 64. This also holds in a cycle that writes word 1.
- R4: Writes to bits 5:0 of word 1 have no effect on the done count.
- R5: A write to word 1 loads the handled count from `reg_wdata[21:16]`.
- R6: An event pulse sets the interrupt-active flag, whatever is written in the same cycle.
- R7: A write to word 1 with bit 8 at zero clears the flag only when the written handled count equals the done count after that cycle's event. Otherwise the flag stays set. A write with bit 8 at one sets the flag.
- R8: `irq` equals the interrupt-active flag ANDed with bit 29 of word 0. Bit 29 is the only writable bit of word 0, and its other bits read zero.
- R9: Word 2 bits 23:0 hold the remaining bytes. `cmd_start` loads `cmd_size`. Each `beat_ok` without `cmd_start` subtracts BEAT_BYTES, modulo 2^24. When both are high in the same cycle, `cmd_start` wins.
- R10: A command whose size field is a multiple of BEAT_BYTES minus one reads all ones (0xFFFFFF) after its last beat.
- R11: The number of pending events, done minus handled modulo 64, equals the number of event pulses since the last full acknowledge. This holds across the wrap of the done count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 1 | One-cycle event from the sequencer (list loaded or command done) |
| cmd_start | input | 1 | Active command starts; load the remaining-bytes counter |
| cmd_size | input | 24 | Size field of the starting command |
| beat_ok | input | 1 | One data beat accepted |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word index: 0 config, 1 counters, 2 remaining bytes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed word (combinational) |
| irq | output | 1 | Level interrupt |

## Verification
The bench sweeps more than 64 events so that the done count wraps. A design with a wrong width or missing wrap would then read the wrong counter value. It acknowledges in the same cycle as a new event. A design that clears the flag without comparing the counts would drop the interrupt, and one that gives the write priority would lose the count. It also writes all ones into the done field, which a design that does not protect that field would take in. On the residue side, it runs commands down to the all-ones wrap and makes start and beat collide. A design that saturates at zero, or that lets the beat win, reads a different value.

// File: rtl/evt_acct_pkg.sv
package evt_acct_pkg;
    localparam int CNT_W    = 6;
    localparam int REG_W    = 32;
    localparam int SIZE_W   = 24;
    localparam int DONE_LSB = 0;
    localparam int ACT_BIT  = 8;
    localparam int PROC_LSB = 16;
    localparam int IEN_BIT  = 29;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t done;
        cnt_t proc;
        logic active;
    } evt_state_t;

    typedef enum logic [1:0] {
        WSEL_CFG  = 2'd0,
        WSEL_CNT  = 2'd1,
        WSEL_RES  = 2'd2,
        WSEL_NONE = 2'd3
    } word_sel_e;

    function automatic logic [REG_W-1:0] pack_counts(evt_state_t s);
        logic [REG_W-1:0] r;
        r = '0;
        r[DONE_LSB +: CNT_W] = s.done;
        r[ACT_BIT]           = s.active;
        r[PROC_LSB +: CNT_W] = s.proc;
        return r;
    endfunction
endpackage

// File: rtl/evt_counter.sv
module evt_counter
    import evt_acct_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       evt,
    input  logic       ack_wr,
    input  cnt_t       ack_proc,
    input  logic       ack_act,
    output evt_state_t st
);
    cnt_t done_n, proc_n;
    logic act_n;

    always_comb begin
        done_n = evt ? st.done + cnt_t'(1) : st.done;
        proc_n = ack_wr ? ack_proc : st.proc;
        if (evt)
            act_n = 1'b1;
        else if (ack_wr)
            act_n = ack_act | (done_n != proc_n);
        else
            act_n = st.active;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st.done   <= done_n;
            st.proc   <= proc_n;
            st.active <= act_n;
        end
    end

    // R3
    done_step_chk: assert property (@(posedge clk) disable iff (rst)
        evt |=> st.done == $past(st.done) + cnt_t'(1));
    // R4
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !evt |=> $stable(st.done));
    // R6
    evt_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        evt |=> st.active);
    // R7
    pending_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (st.done != st.proc) |-> st.active);
endmodule

// File: rtl/xfer_residue.sv
module xfer_residue
    import evt_acct_pkg::*;
#(
    parameter int BEAT_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [SIZE_W-1:0] size,
    input  logic              beat,
    output logic [SIZE_W-1:0] remain
);
    localparam logic [SIZE_W-1:0] BEAT_DEC = SIZE_W'(BEAT_BYTES);

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (start)
            remain <= size;
        else if (beat)
            remain <= remain - BEAT_DEC;
    end

    // R9
    load_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> remain == $past(size));
    // R9
    count_down_chk: assert property (@(posedge clk) disable iff (rst)
        (beat && !start) |=> remain == $past(remain) - BEAT_DEC);
endmodule

// File: rtl/dma_evt_acct.sv
module dma_evt_acct
    import evt_acct_pkg::*;
#(
    parameter int BEAT_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_pulse,
    input  logic              cmd_start,
    input  logic [SIZE_W-1:0] cmd_size,
    input  logic              beat_ok,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq
);
    word_sel_e         wsel;
    evt_state_t        st;
    logic [SIZE_W-1:0] remain;
    logic              ien;
    logic              cnt_wr;

    assign wsel   = word_sel_e'(reg_addr);
    assign cnt_wr = reg_wr && (wsel == WSEL_CNT);

    evt_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt_pulse),
        .ack_wr   (cnt_wr),
        .ack_proc (reg_wdata[PROC_LSB +: CNT_W]),
        .ack_act  (reg_wdata[ACT_BIT]),
        .st       (st)
    );

    xfer_residue #(.BEAT_BYTES(BEAT_BYTES)) u_res (
        .clk    (clk),
        .rst    (rst),
        .start  (cmd_start),
        .size   (cmd_size),
        .beat   (beat_ok),
        .remain (remain)
    );

    always_ff @(posedge clk) begin
        if (rst)
            ien <= 1'b0;
        else if (reg_wr && wsel == WSEL_CFG)
            ien <= reg_wdata[IEN_BIT];
    end

    always_comb begin
        reg_rdata = '0;
        case (wsel)
            WSEL_CFG: reg_rdata[IEN_BIT] = ien;
            WSEL_CNT: reg_rdata = pack_counts(st);
            WSEL_RES: reg_rdata[SIZE_W-1:0] = remain;
            default:  reg_rdata = '0;
        endcase
    end

    assign irq = st.active & ien;

    // R8
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> st.active);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> !irq);
endmodule

// File: tb/dma_evt_acct_tb.sv
module dma_evt_acct_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int BEAT = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        evt_pulse = 1'b0, cmd_start = 1'b0, beat_ok = 1'b0, reg_wr = 1'b0;
    logic [23:0] cmd_size = '0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [5:0]  m_done = 0, m_proc = 0;
    logic        m_act = 0, m_ien = 0;
    logic [23:0] m_rem = 0;

    dma_evt_acct #(.BEAT_BYTES(BEAT)) dut_i (
        .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .cmd_start(cmd_start),
        .cmd_size(cmd_size), .beat_ok(beat_ok), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    function automatic logic [31:0] exp_cnt();
        return {10'd0, m_proc, 7'd0, m_act, 2'd0, m_done};
    endfunction

    // One clock: inputs driven at the negedge, model updated per R3..R9
    task automatic step(input logic ev, input logic wr, input logic [1:0] a,
                        input logic [31:0] wd, input logic st, input logic [23:0] sz,
                        input logic bt);
        logic [5:0] dn, pn;
        evt_pulse = ev; reg_wr = wr; reg_addr = a; reg_wdata = wd;
        cmd_start = st; cmd_size = sz; beat_ok = bt;
        dn = ev ? m_done + 6'd1 : m_done;
        pn = (wr && a == 2'd1) ? wd[21:16] : m_proc;
        if (ev) m_act = 1'b1;
        else if (wr && a == 2'd1) m_act = wd[8] | (dn != pn);
        m_done = dn; m_proc = pn;
        if (wr && a == 2'd0) m_ien = wd[29];
        if (st) m_rem = sz;
        else if (bt) m_rem = m_rem - 24'(BEAT);
        @(posedge clk);
        @(negedge clk);
        evt_pulse = 0; reg_wr = 0; cmd_start = 0; beat_ok = 0;
    endtask

    task automatic verify(input string req);
        logic [31:0] v;
        rd(2'd1, v); chk({req, " counters"}, v, exp_cnt());
        rd(2'd2, v); chk({req, " remain"}, v, {8'd0, m_rem});
        chk({req, " irq"}, {31'd0, irq}, {31'd0, m_act & m_ien});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        rd(2'd0, v); chk("R1 cfg", v, 32'd0);
        rd(2'd1, v); chk("R1 cnt", v, 32'd0);
        rd(2'd2, v); chk("R1 rem", v, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        // R2 unused word
        rd(2'd3, v); chk("R2 word3", v, 32'd0);

        // R3 R6 R11: sweep 70 events, done wraps past 63
        for (int n = 1; n <= 70; n++) begin
            step(1, 0, 2'd1, 0, 0, 0, 0);
            verify("R3 sweep");
            chk("R11 pending", {26'd0, 6'(m_done - m_proc)}, 32'(n % 64));
        end

        // R8 irq gated by enable, other cfg bits read zero
        chk("R8 irq off", {31'd0, irq}, 32'd0);
        step(0, 1, 2'd0, 32'hFFFF_FFFF, 0, 0, 0);
        rd(2'd0, v); chk("R8 cfg bits", v, 32'h2000_0000);
        verify("R8 enabled");

        // R5 R7 partial acknowledge keeps flag
        step(0, 1, 2'd1, {10'd0, m_done - 6'd2, 16'd0}, 0, 0, 0);
        verify("R7 partial ack");
        // R7 full acknowledge clears flag
        step(0, 1, 2'd1, {10'd0, m_done, 16'd0}, 0, 0, 0);
        verify("R7 full ack");
        chk("R7 irq low", {31'd0, irq}, 32'd0);

        // R3 R6 R7 acknowledge racing an event
        step(1, 1, 2'd1, {10'd0, m_done, 16'd0}, 0, 0, 0);
        verify("R6 race");
        chk("R6 race flag", {31'd0, irq}, 32'd1);
        step(0, 1, 2'd1, {10'd0, m_done, 16'd0}, 0, 0, 0);
        verify("R7 after race");

        // R4 write all ones into done field
        step(0, 1, 2'd1, {10'd0, m_done, 16'h003F}, 0, 0, 0);
        verify("R4 done write ignored");
        // R7 write with flag bit set
        step(0, 1, 2'd1, {10'd0, m_done, 16'h0100}, 0, 0, 0);
        verify("R7 set flag");
        step(0, 1, 2'd1, {10'd0, m_done, 16'd0}, 0, 0, 0);

        // R11 pending counts 1..63 after acknowledge, across wrap
        for (int k = 1; k < 64; k += 9) begin
            for (int j = 0; j < k; j++) step(1, 0, 2'd1, 0, 0, 0, 0);
            rd(2'd1, v);
            chk("R11 pending after ack", {26'd0, 6'(v[5:0] - v[21:16])}, 32'(k));
            step(0, 1, 2'd1, {10'd0, m_done, 16'd0}, 0, 0, 0);
            verify("R11 ack");
        end

        // R9 residue countdown
        step(0, 0, 2'd2, 0, 1, 24'd100, 0);
        verify("R9 load");
        for (int b = 0; b < 26; b++) begin
            step(0, 0, 2'd2, 0, 0, 0, 1);
            verify("R9 beat");
        end
        chk("R9 wrapped", {8'd0, m_rem}, 32'h00FF_FFFC);
        // R9 start wins over beat
        step(0, 0, 2'd2, 0, 1, 24'd15, 1);
        verify("R9 start priority");
        // R10 size 15 with 4 beats ends all ones
        for (int b = 0; b < 4; b++) step(0, 0, 2'd2, 0, 0, 0, 1);
        rd(2'd2, v); chk("R10 all ones", v, 32'h00FF_FFFF);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule